// File: doc/BRIEF.md
# Burst Test Pattern Generator

This block drives stored stimulus patterns onto a small group of parallel channels that feed a high-speed tester front end. A host fills an on-chip pattern memory and sets the run shape through a narrow register write port. A start command then makes the block emit one channel word per clock. Each word comes with a presence strobe that marks it valid and, on chosen words, a one-cycle trigger that an oscilloscope can lock to. Words are grouped into bursts of programmable length with idle gaps between them, and a run ends by itself after a programmed number of bursts.

Pattern words are read in address order and wrap at a programmable pattern length, so a short pattern repeats across bursts. A run can be cut short by an abort command, which silences the channels on the next cycle. The register settings and the pattern memory are frozen while a run is active, so a run always follows one consistent configuration. A done flag shows that the last run finished on its own.

Top module: `burst_pattern_gen`

## Requirements
- R1: After reset, ch_data is 0, presence, trigger, busy and done are 0.
- R2: A write to register 0 with bit 0 set while busy is low starts a run. busy is high after the edge that samples the write. The first word appears after the next edge. Each burst presents L consecutive words with presence high, where register 1 holds L-1 (8 bits, so L is 1 to 256).
- R3: Between two bursts of a run the block spends G cycles with presence low and ch_data 0, where register 2 holds G-1 (1 to 256). ch_data is 0 in every cycle in which presence is low.
- R4: Register 6 writes one pattern word, with data in bits [3:0] and address in bits [11:4]. Words are read from address 0 upwards and wrap to 0 after address P-1, where register 4 holds P-1. The address carries on across bursts, and every new run restarts at address 0.
- R5: When bit 0 of register 5 is 1, trigger is high for one cycle with the first word of every burst. When that bit is 0, trigger is high only with the first word of the run. trigger is never high while presence is low.
- R6: Register 3 holds N-1, where N is the number of bursts in a run (1 to 256). In the cycle in which the final word of burst N is presented, done is high and busy is low. In the following cycle presence is low and ch_data is 0. A start clears done.
- R7: While busy is high, a start write is ignored. Writes to registers 1 to 6 are also ignored, so neither the run shape nor the pattern memory changes.
- R8: A write to register 0 with bit 1 set while busy is high aborts the run. From the next cycle on, presence, trigger and ch_data are 0, busy is low and done stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pattern clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 12 | Register write data |
| ch_data | output | 4 | Stimulus word on the four channels |
| presence | output | 1 | High when ch_data carries a valid word |
| trigger | output | 1 | One-cycle oscilloscope sync pulse |
| busy | output | 1 | A run is active |
| done | output | 1 | The last run completed without abort |

## Verification
The assertions check rules that must hold in every cycle. The channel lines are zero whenever presence is low, and trigger never appears without presence. The pattern address stays inside the programmed length during a run. The run shape is frozen while busy. An abort silences the outputs on the next cycle, and the end of a run raises done with busy low. Only the bench scenarios can show the exact word order, burst and gap lengths, wrap points and trigger placement. They do this by comparing each cycle of a run against a sequence the bench builds from the register values, including runs where start and configuration writes arrive mid-run and have no effect.

// File: rtl/bpg_pkg.sv
package bpg_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_BURST = 2'd1,
    PH_GAP   = 2'd2
  } phase_e;

  // register addresses
  localparam logic [2:0] RA_CMD   = 3'd0;
  localparam logic [2:0] RA_BLEN  = 3'd1;
  localparam logic [2:0] RA_GLEN  = 3'd2;
  localparam logic [2:0] RA_BCNT  = 3'd3;
  localparam logic [2:0] RA_PLEN  = 3'd4;
  localparam logic [2:0] RA_MODE  = 3'd5;
  localparam logic [2:0] RA_PWORD = 3'd6;

  // command bit positions in register 0
  localparam int CMD_START_BIT = 0;
  localparam int CMD_ABORT_BIT = 1;

endpackage

// File: rtl/bpg_regs.sv
module bpg_regs
  import bpg_pkg::*;
#(
  parameter int DATA_W = 4,
  parameter int PAT_AW = 8,
  parameter int LEN_W  = 8,
  localparam int REG_DW = PAT_AW + DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  input  logic              busy,
  output logic [LEN_W-1:0]  burst_m1,
  output logic [LEN_W-1:0]  gap_m1,
  output logic [LEN_W-1:0]  count_m1,
  output logic [PAT_AW-1:0] pat_m1,
  output logic              trig_each,
  output logic              start_req,
  output logic              abort_req,
  output logic              pat_we,
  output logic [PAT_AW-1:0] pat_waddr,
  output logic [DATA_W-1:0] pat_wdata
);

  logic cfg_open;
  logic cmd_hit;

  assign cfg_open  = reg_wr && !busy;
  assign cmd_hit   = reg_wr && (reg_addr == RA_CMD);
  // abort wins over start in the same write
  assign abort_req = cmd_hit && busy && reg_wdata[CMD_ABORT_BIT];
  assign start_req = cmd_hit && !busy && reg_wdata[CMD_START_BIT];

  assign pat_we    = cfg_open && (reg_addr == RA_PWORD);
  assign pat_waddr = reg_wdata[DATA_W +: PAT_AW];
  assign pat_wdata = reg_wdata[DATA_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burst_m1  <= '0;
      gap_m1    <= '0;
      count_m1  <= '0;
      pat_m1    <= '0;
      trig_each <= 1'b0;
    end else if (cfg_open) begin
      case (reg_addr)
        RA_BLEN: burst_m1  <= reg_wdata[LEN_W-1:0];
        RA_GLEN: gap_m1    <= reg_wdata[LEN_W-1:0];
        RA_BCNT: count_m1  <= reg_wdata[LEN_W-1:0];
        RA_PLEN: pat_m1    <= reg_wdata[PAT_AW-1:0];
        RA_MODE: trig_each <= reg_wdata[0];
        default: ;
      endcase
    end
  end

  // R7: run shape is frozen while a run is active
  a_r7_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr && reg_addr != RA_CMD)
      |=> $stable({burst_m1, gap_m1, count_m1, pat_m1, trig_each}));

endmodule

// File: rtl/bpg_pattern_ram.sv
module bpg_pattern_ram #(
  parameter int DATA_W = 4,
  parameter int PAT_AW = 8,
  localparam int DEPTH = 1 << PAT_AW
) (
  input  logic              clk,
  input  logic              we,
  input  logic [PAT_AW-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [PAT_AW-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/bpg_sequencer.sv
module bpg_sequencer
  import bpg_pkg::*;
#(
  parameter int PAT_AW = 8,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  logic              abort_req,
  input  logic [LEN_W-1:0]  burst_m1,
  input  logic [LEN_W-1:0]  gap_m1,
  input  logic [LEN_W-1:0]  count_m1,
  input  logic [PAT_AW-1:0] pat_m1,
  input  logic              trig_each,
  output logic              busy,
  output logic              done,
  output logic              emit_valid,
  output logic              emit_trig,
  output logic [PAT_AW-1:0] rd_addr,
  output logic              run_end
);

  function automatic logic [PAT_AW-1:0] wrap_next(input logic [PAT_AW-1:0] cur,
                                                  input logic [PAT_AW-1:0] last);
    return (cur == last) ? '0 : cur + 1'b1;
  endfunction

  function automatic logic [LEN_W-1:0] step(input logic [LEN_W-1:0] c);
    return c + 1'b1;
  endfunction

  phase_e            phase;
  logic [LEN_W-1:0]  word_cnt;
  logic [LEN_W-1:0]  burst_cnt;
  logic [PAT_AW-1:0] pat_addr;

  logic word_end;
  logic gap_end;
  logic first_word;

  assign busy       = (phase != PH_IDLE);
  assign emit_valid = (phase == PH_BURST);
  assign word_end   = emit_valid && (word_cnt == burst_m1);
  assign gap_end    = (phase == PH_GAP) && (word_cnt == gap_m1);
  assign run_end    = word_end && (burst_cnt == count_m1);
  assign first_word = emit_valid && (word_cnt == '0);
  assign emit_trig  = first_word && (trig_each || burst_cnt == '0);
  assign rd_addr    = pat_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      word_cnt  <= '0;
      burst_cnt <= '0;
      pat_addr  <= '0;
      done      <= 1'b0;
    end else if (abort_req) begin
      phase <= PH_IDLE;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (start_req) begin
            phase     <= PH_BURST;
            word_cnt  <= '0;
            burst_cnt <= '0;
            pat_addr  <= '0;
            done      <= 1'b0;
          end
        end
        PH_BURST: begin
          pat_addr <= wrap_next(pat_addr, pat_m1);
          if (word_end) begin
            word_cnt <= '0;
            if (run_end) begin
              phase <= PH_IDLE;
              done  <= 1'b1;
            end else begin
              burst_cnt <= step(burst_cnt);
              phase     <= PH_GAP;
            end
          end else begin
            word_cnt <= step(word_cnt);
          end
        end
        PH_GAP: begin
          if (gap_end) begin
            word_cnt <= '0;
            phase    <= PH_BURST;
          end else begin
            word_cnt <= step(word_cnt);
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R4: read address stays inside the programmed pattern
  a_r4_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (pat_addr <= pat_m1));

  // R6: a completed run leaves done set and the sequencer idle
  a_r6_end_sets_done: assert property (@(posedge clk) disable iff (!rst_n)
    (run_end && !abort_req) |=> (done && !busy));

  // R6: done and busy are never high together
  a_r6_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

// File: rtl/burst_pattern_gen.sv
module burst_pattern_gen
  import bpg_pkg::*;
#(
  parameter int DATA_W = 4,
  parameter int PAT_AW = 8,
  parameter int LEN_W  = 8,
  localparam int REG_DW = PAT_AW + DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [DATA_W-1:0] ch_data,
  output logic              presence,
  output logic              trigger,
  output logic              busy,
  output logic              done
);

  logic [LEN_W-1:0]  burst_m1, gap_m1, count_m1;
  logic [PAT_AW-1:0] pat_m1;
  logic              trig_each;
  logic              start_req, abort_req;
  logic              pat_we;
  logic [PAT_AW-1:0] pat_waddr;
  logic [DATA_W-1:0] pat_wdata;
  logic [PAT_AW-1:0] rd_addr;
  logic [DATA_W-1:0] rd_data;
  logic              emit_valid, emit_trig, run_end;
  logic              send_now;

  bpg_regs #(.DATA_W(DATA_W), .PAT_AW(PAT_AW), .LEN_W(LEN_W)) u_regs (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .busy,
    .burst_m1, .gap_m1, .count_m1, .pat_m1, .trig_each,
    .start_req, .abort_req, .pat_we, .pat_waddr, .pat_wdata
  );

  bpg_pattern_ram #(.DATA_W(DATA_W), .PAT_AW(PAT_AW)) u_ram (
    .clk, .we(pat_we), .waddr(pat_waddr), .wdata(pat_wdata),
    .raddr(rd_addr), .rdata(rd_data)
  );

  bpg_sequencer #(.PAT_AW(PAT_AW), .LEN_W(LEN_W)) u_seq (
    .clk, .rst_n, .start_req, .abort_req,
    .burst_m1, .gap_m1, .count_m1, .pat_m1, .trig_each,
    .busy, .done, .emit_valid, .emit_trig, .rd_addr, .run_end
  );

  // an abort silences the output stage in the same edge
  assign send_now = emit_valid && !abort_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_data  <= '0;
      presence <= 1'b0;
      trigger  <= 1'b0;
    end else begin
      ch_data  <= send_now ? rd_data : '0;
      presence <= send_now;
      trigger  <= send_now && emit_trig;
    end
  end

  // R3: idle lines carry zero
  a_r3_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !presence |-> (ch_data == '0));

  // R5: trigger only with a valid word
  a_r5_trig_needs_presence: assert property (@(posedge clk) disable iff (!rst_n)
    trigger |-> presence);

  // R8: abort quiets the outputs on the next cycle
  a_r8_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |=> (!presence && !trigger && !busy && !done));

endmodule

// File: tb/burst_pattern_gen_tb.sv
module burst_pattern_gen_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NPAT = 32;
  localparam int MAXC = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [11:0] reg_wdata = '0;
  logic [3:0]  ch_data;
  logic        presence, trigger, busy, done;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [3:0] pat_tb [NPAT];
  logic [3:0] exp_d [MAXC];
  logic       exp_p [MAXC];
  logic       exp_t [MAXC];

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_pattern_gen u_dut (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata,
    .ch_data, .presence, .trigger, .busy, .done
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic write_reg(input logic [2:0] a, input logic [11:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic configure(input int L, input int G, input int B, input int P,
                           input bit each);
    write_reg(3'd1, 12'(L - 1));
    write_reg(3'd2, 12'(G - 1));
    write_reg(3'd3, 12'(B - 1));
    write_reg(3'd4, 12'(P - 1));
    write_reg(3'd5, {11'd0, each});
  endtask

  // start a run and compare every cycle against the expected sequence;
  // optionally inject one register write at cycle inj_k of the run
  task automatic run_and_check(input int L, input int G, input int B, input int P,
                               input bit each, input int inj_k,
                               input logic [2:0] inj_a, input logic [11:0] inj_d,
                               input string tag);
    int total = 0;
    int addr = 0;
    for (int b = 0; b < B; b++) begin
      for (int w = 0; w < L; w++) begin
        exp_d[total] = pat_tb[addr];
        exp_p[total] = 1'b1;
        exp_t[total] = (w == 0) && (each || b == 0);
        addr = (addr + 1) % P;
        total++;
      end
      if (b < B - 1) begin
        for (int g = 0; g < G; g++) begin
          exp_d[total] = 4'd0; exp_p[total] = 1'b0; exp_t[total] = 1'b0;
          total++;
        end
      end
    end
    write_reg(3'd0, 12'h001);
    chk(busy === 1'b1 && done === 1'b0, "R2", {tag, " busy/done after start"},
        {busy, done}, 2'b10);
    for (int k = 0; k < total; k++) begin
      @(negedge clk);
      reg_wr = 1'b0;
      chk({ch_data, presence, trigger} === {exp_d[k], exp_p[k], exp_t[k]},
          "R2 R3 R4 R5", $sformatf("%s cycle %0d {data,pres,trig}", tag, k),
          {ch_data, presence, trigger}, {exp_d[k], exp_p[k], exp_t[k]});
      if (k == total - 1)
        chk(done === 1'b1 && busy === 1'b0, "R6", {tag, " done/busy on last word"},
            {done, busy}, 2'b10);
      if (k == inj_k) begin
        reg_wr = 1'b1; reg_addr = inj_a; reg_wdata = inj_d;
      end
    end
    @(negedge clk);
    reg_wr = 1'b0;
    chk({ch_data, presence, trigger, busy, done} === {4'd0, 1'b0, 1'b0, 1'b0, 1'b1},
        "R6", {tag, " idle after run"}, {ch_data, presence, trigger, busy, done},
        {4'd0, 4'b0001});
  endtask

  task automatic t_reset;
    chk({ch_data, presence, trigger, busy, done} === 8'd0, "R1", "reset state",
        {ch_data, presence, trigger, busy, done}, 0);
  endtask

  task automatic t_load_pattern;
    for (int i = 0; i < NPAT; i++) begin
      pat_tb[i] = 4'((i * 5 + 3) % 16);
      write_reg(3'd6, {8'(i), pat_tb[i]});
    end
  endtask

  task automatic t_basic;   // R2 R3 R4 R5: trigger on every burst
    configure(4, 3, 3, 16, 1'b1);
    run_and_check(4, 3, 3, 16, 1'b1, -1, 3'd0, 12'd0, "basic");
  endtask

  task automatic t_wrap;    // R4 R5: short pattern, trigger once per run
    configure(5, 1, 3, 3, 1'b0);
    run_and_check(5, 1, 3, 3, 1'b0, -1, 3'd0, 12'd0, "wrap");
    run_and_check(5, 1, 3, 3, 1'b0, -1, 3'd0, 12'd0, "wrap-restart");
  endtask

  task automatic t_bounds;  // R2 R3 R6: minimum and maximum lengths
    configure(1, 1, 1, 1, 1'b1);
    run_and_check(1, 1, 1, 1, 1'b1, -1, 3'd0, 12'd0, "min");
    configure(1, 1, 4, 32, 1'b0);
    run_and_check(1, 1, 4, 32, 1'b0, -1, 3'd0, 12'd0, "single-word-bursts");
    configure(256, 256, 2, 32, 1'b1);
    run_and_check(256, 256, 2, 32, 1'b1, -1, 3'd0, 12'd0, "max");
  endtask

  task automatic t_busy_ignore;  // R7
    configure(6, 2, 2, 16, 1'b1);
    run_and_check(6, 2, 2, 16, 1'b1, 3, 3'd0, 12'h001, "R7 start-mid-run");
    run_and_check(6, 2, 2, 16, 1'b1, 4, 3'd1, 12'h001, "R7 blen-mid-run");
    run_and_check(6, 2, 2, 16, 1'b1, 2, 3'd6, {8'd1, 4'hF}, "R7 pword-mid-run");
    // later run still uses length 6 and the original word at address 1
    run_and_check(6, 2, 2, 16, 1'b1, -1, 3'd0, 12'd0, "R7 cfg-kept");
  endtask

  task automatic t_abort;   // R8
    configure(8, 2, 4, 16, 1'b1);
    write_reg(3'd0, 12'h001);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(presence === 1'b1 && ch_data === pat_tb[k], "R8", "word before abort",
          {ch_data, presence}, {pat_tb[k], 1'b1});
    end
    reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 12'h002;
    @(negedge clk);
    reg_wr = 1'b0;
    chk({ch_data, presence, trigger, busy, done} === 8'd0, "R8", "outputs after abort",
        {ch_data, presence, trigger, busy, done}, 0);
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      chk({presence, busy, done} === 3'd0, "R8", "stays quiet after abort",
          {presence, busy, done}, 0);
    end
    run_and_check(8, 2, 4, 16, 1'b1, -1, 3'd0, 12'd0, "R8 run after abort");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog (R1..R8 run) actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load_pattern();
    t_basic();
    t_wrap();
    t_bounds();
    t_busy_ignore();
    t_abort();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule